// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and a 32K x 8 asynchronous static RAM. The host hands over one request at a time with a valid/ready handshake: a 15-bit address, a write flag and a byte of write data. The controller then produces the memory's active-low chip enable, write enable and output enable, holds the address steady, and controls the direction of the shared 8-bit data bus. Read data is registered and returned with a single-cycle valid strobe.

Every memory timing interval is a parameter counted in clock cycles, so the block can be matched to a speed grade and clock rate. A read keeps the chip selected with output enable low for the access count plus one capture cycle. A write drives data from its first cycle, keeps output enable high throughout, pulses write enable low for the pulse count, and ends by raising chip enable and write enable in the same cycle while the data stays driven for a hold count. When a write follows a read, the controller waits a turnaround count with the bus undriven before it drives anything. Between requests the chip is deselected, which puts the memory into its power-down state.

The data bus is presented as separate in, out and output-enable signals; the pad that joins them lies outside the block.

Top module: `asram_bridge`

## Requirements
- R1: During and after reset, and whenever no request is in progress, memCeN, memWeN and memOeN are 1, memDqOe is 0 and reqReady is 1.
- R2: An accepted read (reqWrite = 0) holds memCeN = 0, memOeN = 0, memWeN = 1 and memAddr equal to the request address for RD_CYC + 1 cycles, starting in the cycle after acceptance, with memDqOe = 0.
- R3: The value on memDqIn in the last cycle of a read is placed on rdData, and rdValid is 1 for exactly the following cycle.
- R4: An accepted write (reqWrite = 1) first spends WR_SETUP_CYC cycles with memCeN = 0, memWeN = 1 and the data driven, then WR_PULSE_CYC cycles with memCeN = 0 and memWeN = 0; throughout, memAddr and memDqOut equal the request address and data and memDqOe = 1.
- R5: A write is ended by memCeN and memWeN rising in the same cycle, after which memDqOe stays 1 with address and data unchanged for WR_REC_CYC cycles.
- R6: memOeN is 1 in every cycle of a write, and memDqOe is never 1 while memOeN is 0.
- R7: A write accepted when the previous operation was a read is preceded by TURN_CYC cycles with all strobes high and memDqOe = 0; a write after a write, or the first write after reset, has no such delay.
- R8: reqReady is 1 only when the controller is idle, so from acceptance to the last cycle of an operation it is 0 and the next request is taken in the first idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Controller can take a request |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqAddr | input | 15 | Request word address |
| reqWdata | input | 8 | Write data |
| rdValid | output | 1 | One-cycle strobe, rdData holds fresh read data |
| rdData | output | 8 | Last captured read data |
| memAddr | output | 15 | Memory address lines |
| memCeN | output | 1 | Memory chip enable, active low |
| memWeN | output | 1 | Memory write enable, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memDqOut | output | 8 | Data to the memory bus |
| memDqOe | output | 1 | Drive enable for memDqOut |
| memDqIn | input | 8 | Data from the memory bus |

## Verification
The assertions take for granted that the host changes reqAddr, reqWrite and reqWdata only while a request can be accepted, so the latched address is the only thing that reaches memAddr during an operation, and that memDqIn is settled by the capture cycle. The bench drives requests only in cycles its model predicts as idle and holds reqValid low otherwise, and its memory model returns stored bytes only while chip enable and output enable are low with write enable high. Request fields are changed on the falling clock edge, so no assumption about input setup is ever stretched.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_CAP,
    ST_WR_SU,
    ST_WR_PULSE,
    ST_WR_REC,
    ST_TURN
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch request fields
    logic capture;  // sample the memory data bus
    logic drive;    // enable the data-bus output driver
  } ctlStrobe_t;

endpackage

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int RD_CYC       = 2,
  parameter int WR_SETUP_CYC = 1,
  parameter int WR_PULSE_CYC = 1,
  parameter int WR_REC_CYC   = 1,
  parameter int TURN_CYC     = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output logic       memCeN,
  output logic       memWeN,
  output logic       memOeN,
  output ctlStrobe_t strb
);

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_CYC = maxOf(maxOf(maxOf(RD_CYC, WR_SETUP_CYC), maxOf(WR_PULSE_CYC, WR_REC_CYC)), TURN_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_SU   = CNT_W'(WR_SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_PW   = CNT_W'(WR_PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] LD_REC  = CNT_W'(WR_REC_CYC - 1);
  localparam logic [CNT_W-1:0] LD_TURN = CNT_W'(TURN_CYC - 1);

  ctlState_e       state;
  logic [CNT_W-1:0] cnt;
  logic             afterRead;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      afterRead <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            if (reqWrite) begin
              afterRead <= 1'b0;
              if (afterRead) begin
                state <= ST_TURN;
                cnt   <= LD_TURN;
              end else begin
                state <= ST_WR_SU;
                cnt   <= LD_SU;
              end
            end else begin
              afterRead <= 1'b1;
              state     <= ST_RD_ACC;
              cnt       <= LD_RD;
            end
          end
        end
        default: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            case (state)
              ST_RD_ACC:   state <= ST_RD_CAP;
              ST_TURN:     begin state <= ST_WR_SU;    cnt <= LD_SU;  end
              ST_WR_SU:    begin state <= ST_WR_PULSE; cnt <= LD_PW;  end
              ST_WR_PULSE: begin state <= ST_WR_REC;   cnt <= LD_REC; end
              default:     state <= ST_IDLE;
            endcase
          end
        end
      endcase
    end
  end

  always_comb begin
    reqReady     = (state == ST_IDLE);
    memCeN       = !(state == ST_RD_ACC || state == ST_RD_CAP ||
                     state == ST_WR_SU  || state == ST_WR_PULSE);
    memWeN       = (state != ST_WR_PULSE);
    memOeN       = !(state == ST_RD_ACC || state == ST_RD_CAP);
    strb.load    = (state == ST_IDLE) && reqValid;
    strb.capture = (state == ST_RD_CAP);
    strb.drive   = (state == ST_WR_SU || state == ST_WR_PULSE || state == ST_WR_REC);
  end

  AST_WE_NEEDS_CE: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> !memCeN);                                   // R4
  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN);                                    // R6
  AST_END_TOGETHER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> $rose(memCeN));                       // R5
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCeN && memWeN && memOeN && !strb.drive)); // R8

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath
  import asram_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid
);

  logic [ADDR_W-1:0] addrReg;
  logic [DATA_W-1:0] wdataReg;
  logic [DATA_W-1:0] rdReg;
  logic              rvReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      wdataReg <= '0;
      rdReg    <= '0;
      rvReg    <= 1'b0;
    end else begin
      if (strb.load) begin
        addrReg  <= reqAddr;
        wdataReg <= reqWdata;
      end
      if (strb.capture) rdReg <= memDqIn;
      rvReg <= strb.capture;
    end
  end

  assign memAddr  = addrReg;
  assign memDqOut = wdataReg;
  assign memDqOe  = strb.drive;
  assign rdData   = rdReg;
  assign rdValid  = rvReg;

  AST_RDVALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);                                  // R3
  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (memDqOe && $past(memDqOe)) |-> $stable(memDqOut));     // R5

endmodule

// File: rtl/asram_bridge.sv
module asram_bridge
  import asram_pkg::*;
#(
  parameter int ADDR_W       = 15,
  parameter int DATA_W       = 8,
  parameter int RD_CYC       = 2,
  parameter int WR_SETUP_CYC = 1,
  parameter int WR_PULSE_CYC = 1,
  parameter int WR_REC_CYC   = 1,
  parameter int TURN_CYC     = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  ctlStrobe_t strb;

  asram_ctrl #(
    .RD_CYC(RD_CYC), .WR_SETUP_CYC(WR_SETUP_CYC), .WR_PULSE_CYC(WR_PULSE_CYC),
    .WR_REC_CYC(WR_REC_CYC), .TURN_CYC(TURN_CYC)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN),
    .strb(strb)
  );

  asram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .memDqIn(memDqIn), .memAddr(memAddr), .memDqOut(memDqOut), .memDqOe(memDqOe),
    .rdData(rdData), .rdValid(rdValid)
  );

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> memOeN);                                    // R6
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));      // R2
  AST_DRIVE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memDqOe) |-> (memOeN && $past(memOeN)));          // R7

endmodule

// File: tb/sim_asram_bridge.sv
module sim_asram_bridge;

  localparam int RD   = 3;
  localparam int SU   = 1;
  localparam int PW   = 2;
  localparam int REC  = 1;
  localparam int TA   = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [14:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        rdValid;
  logic [7:0]  rdData;
  logic [14:0] memAddr;
  logic        memCeN, memWeN, memOeN, memDqOe;
  logic [7:0]  memDqOut, memDqIn;

  always #4 clk = ~clk;

  asram_bridge #(
    .RD_CYC(RD), .WR_SETUP_CYC(SU), .WR_PULSE_CYC(PW), .WR_REC_CYC(REC), .TURN_CYC(TA)
  ) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData), .memAddr(memAddr), .memCeN(memCeN),
    .memWeN(memWeN), .memOeN(memOeN), .memDqOut(memDqOut), .memDqOe(memDqOe),
    .memDqIn(memDqIn)
  );

  // behavioural memory: sparse storage, write commits when the pulse ends
  logic [7:0] bmem [int];
  logic        pend = 1'b0;
  logic [14:0] pendA;
  logic [7:0]  pendD;

  function automatic logic [7:0] memRead(logic [14:0] a);
    return bmem.exists(int'(a)) ? bmem[int'(a)] : 8'h00;
  endfunction

  assign memDqIn = (!memCeN && !memOeN && memWeN) ? memRead(memAddr) : 8'hEE;

  always @(negedge clk) begin
    if (!memCeN && !memWeN) begin
      pend  <= 1'b1;
      pendA <= memAddr;
      pendD <= memDqOut;
    end else if (pend) begin
      bmem[int'(pendA)] = pendD;
      pend <= 1'b0;
    end
  end

  typedef struct {
    bit ce, we, oe, drv, rdy, rv, chkA, chkD, chkRd, isWr;
    logic [14:0] a;
    logic [7:0]  d;
    string tag;
  } exp_t;

  typedef struct {
    bit wr;
    logic [14:0] a;
    logic [7:0]  d;
    int gap;
  } op_t;

  exp_t q[$];
  op_t  ops[$];
  logic [7:0] refMem [int];
  int checks = 0;
  int fails = 0;
  bit lastRd = 0;
  bit done = 0;

  task automatic cmp(string tag, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, expv, $time);
    end
  endtask

  function automatic exp_t idleItem();
    exp_t e;
    e.ce = 1; e.we = 1; e.oe = 1; e.drv = 0; e.rdy = 1; e.rv = 0;
    e.chkA = 0; e.chkD = 0; e.chkRd = 0; e.isWr = 0; e.a = '0; e.d = '0;
    e.tag = "R1";
    return e;
  endfunction

  function automatic exp_t busy(bit ce, bit we, bit oe, bit drv, logic [14:0] a,
                                logic [7:0] d, bit chkA, bit wr, string tag);
    exp_t e = idleItem();
    e.ce = ce; e.we = we; e.oe = oe; e.drv = drv; e.rdy = 0;
    e.a = a; e.d = d; e.chkA = chkA; e.chkD = drv; e.isWr = wr; e.tag = tag;
    return e;
  endfunction

  task automatic pushOp(op_t o);
    if (o.wr) begin
      if (lastRd)
        for (int i = 0; i < TA; i++) q.push_back(busy(1, 1, 1, 0, o.a, o.d, 0, 1, "R7"));
      for (int i = 0; i < SU; i++)  q.push_back(busy(0, 1, 1, 1, o.a, o.d, 1, 1, "R4"));
      for (int i = 0; i < PW; i++)  q.push_back(busy(0, 0, 1, 1, o.a, o.d, 1, 1, "R4"));
      for (int i = 0; i < REC; i++) q.push_back(busy(1, 1, 1, 1, o.a, o.d, 1, 1, "R5"));
      refMem[int'(o.a)] = o.d;
      lastRd = 0;
    end else begin
      exp_t e;
      for (int i = 0; i < RD + 1; i++) q.push_back(busy(0, 1, 0, 0, o.a, o.d, 1, 0, "R2"));
      e = idleItem();
      e.rv = 1; e.chkRd = 1; e.tag = "R3";
      e.d = refMem.exists(int'(o.a)) ? refMem[int'(o.a)] : 8'h00;
      q.push_back(e);
      lastRd = 1;
    end
  endtask

  task automatic checkCycle(exp_t e);
    cmp(e.tag, "memCeN", memCeN, e.ce);
    cmp(e.tag, "memWeN", memWeN, e.we);
    cmp(e.isWr ? "R6" : e.tag, "memOeN", memOeN, e.oe);
    cmp(e.tag, "memDqOe", memDqOe, e.drv);
    cmp("R8", "reqReady", reqReady, e.rdy);
    cmp(e.tag, "rdValid", rdValid, e.rv);
    if (e.chkA)  cmp(e.tag, "memAddr", memAddr, e.a);
    if (e.chkD)  cmp(e.tag, "memDqOut", memDqOut, e.d);
    if (e.chkRd) cmp(e.tag, "rdData", rdData, e.d);
  endtask

  function automatic op_t mk(bit wr, logic [14:0] a, logic [7:0] d, int gap);
    op_t o;
    o.wr = wr; o.a = a; o.d = d; o.gap = gap;
    return o;
  endfunction

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    int idx = 0;
    int gap = 0;
    int tail = 0;
    exp_t e;

    // directed: boundaries, write after write, read after read, write after read
    ops.push_back(mk(1, 15'h0000, 8'h5A, 0));
    ops.push_back(mk(1, 15'h7FFF, 8'hA5, 0));
    ops.push_back(mk(0, 15'h0000, 8'h00, 0));
    ops.push_back(mk(0, 15'h7FFF, 8'h00, 0));
    ops.push_back(mk(1, 15'h1234, 8'h3C, 0));
    ops.push_back(mk(0, 15'h1234, 8'h00, 2));
    ops.push_back(mk(1, 15'h0000, 8'hC3, 1));
    ops.push_back(mk(0, 15'h0000, 8'h00, 0));
    ops.push_back(mk(0, 15'h4321, 8'h00, 3));
    for (int i = 0; i < 40; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ops.push_back(mk(lfsr[0], {12'h0F0, lfsr[3:1]}, lfsr[11:4], int'(lfsr[14:13]) & 1));
    end

    // reset: R1 checked while held and after release
    repeat (3) begin
      @(negedge clk);
      checkCycle(idleItem());
    end
    rstN = 1'b1;

    while (!(idx >= ops.size() && q.size() == 0 && tail > 3)) begin
      @(negedge clk);
      e = (q.size() != 0) ? q.pop_front() : idleItem();
      checkCycle(e);
      reqValid = 1'b0;
      if (idx >= ops.size() && q.size() == 0) tail++;
      if (e.rdy && q.size() == 0 && idx < ops.size()) begin
        if (gap > 0) begin
          gap--;
        end else begin
          reqValid = 1'b1;
          reqWrite = ops[idx].wr;
          reqAddr  = ops[idx].a;
          reqWdata = ops[idx].d;
          pushOp(ops[idx]);
          idx++;
          if (idx < ops.size()) gap = ops[idx].gap;
        end
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule